// File: doc/BRIEF.md
# Quad-lane asynchronous SRAM controller

This block connects a synchronous host port to an asynchronous static RAM made of four independent byte lanes. The lanes share one address bus and one active-low output enable. Each lane has its own active-low chip select and write enable. The host raises a request together with an address, write data, byte enables and a read/write flag, and holds them until the controller answers with a one-cycle ready pulse. For a read, the returned data is valid during that pulse.

A static width input arranges the lanes in one of three ways: as one 32-bit bank, as two 16-bit banks (lane pairs 0/1 and 2/3), or as four 8-bit banks. The host address is a byte address of `MEM_AW+2` bits. The controller turns it into a lane address, one or more active chip selects and per-lane write strobes.

Every phase of a memory cycle lasts a whole number of clock cycles. Each length is the nanosecond minimum of the memory rounded up to whole clock periods, with at least one cycle per phase. All memory-side strobes leave the block straight from flip-flops.

Top module: `qlane_sram_ctrl`

## Requirements
- R1: With width code 2'b00, an access asserts all four chip selects together. Lane address = host address bits [MEM_AW+1:2]. Lane k is written only when byte enable k is set. Read data returns lane k on rdata bits [8k+7:8k].
- R2: With width code 2'b01, host address bit MEM_AW+1 picks the bank: 0 selects lanes 0 and 1, 1 selects lanes 2 and 3. Lane address = bits [MEM_AW:1]. Host data bits [15:0] and enables [1:0] map to the lower and upper lane of the bank. Read data returns on rdata[15:0] with rdata[31:16] zero.
- R3: With width code 2'b10, host address bits [MEM_AW+1:MEM_AW] pick the single lane. Lane address = bits [MEM_AW-1:0]. Write data comes from wdata[7:0] gated by be[0]. Read data returns on rdata[7:0] with the upper bits zero.
- R4: Width code 2'b11 behaves exactly like 2'b00.
- R5: During a write, chip select stays low from setup to recovery. Write enable is low for exactly `max(ceil(T_WP/CLK_NS), ceil(T_DS/CLK_NS))` cycles, never while chip select is high, and the address is stable while write enable is low.
- R6: A write without a preceding read gives ready `N_AS+N_WP+N_REC+1` clock edges after the accepting edge, counting that edge. Here N_AS = ceil(T_AS/CLK_NS), N_REC = max(1, ceil(T_WC/CLK_NS)-N_AS-N_WP), and every count is at least 1.
- R7: A read holds chip select and output enable low for N_RD = ceil(T_AA/CLK_NS) cycles. It captures the data on the last of those cycles and gives ready N_RD+1 edges after acceptance. Output enable is never low while any write enable is low.
- R8: The data driver enable is high only while write enable is low and in the one cycle after it rises. It is never high while output enable is low.
- R9: A write accepted after a completed read first spends N_TA = ceil(T_HZ/CLK_NS) cycles with all chip selects and output enable high, so its ready comes N_TA cycles later than in R6.
- R10: Ready is high for exactly one cycle per transaction, and all chip selects are high in that cycle.
- R11: While reset is low, all chip selects and write enables are high, output enable is high, and the driver enable and ready are low.
- R12: A write lane whose byte enable is clear keeps its write enable high, and its stored byte is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_i | input | 2 | Static width code: 00/11 one 32-bit bank, 01 two 16-bit banks, 10 four 8-bit banks |
| req_i | input | 1 | Transaction request, held until ready |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | MEM_AW+2 | Host byte address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data, valid with ready |
| mem_addr_o | output | MEM_AW | Shared lane address |
| mem_cs_n_o | output | 4 | Per-lane chip select, active low |
| mem_we_n_o | output | 4 | Per-lane write enable, active low |
| mem_oe_n_o | output | 1 | Shared output enable, active low |
| mem_dq_o | output | 32 | Data toward the memory |
| mem_dq_oe_o | output | 1 | Enable for the data driver toward the memory |
| mem_dq_i | input | 32 | Data from the memory |

## Verification
The bench builds the controller with MEM_AW=3, so each lane holds eight bytes. At 10 ns per clock and fast-grade minimums, the phases last 1, 2, 1, 2 and 1 cycles. This small array lets the bench write and read back every address in every width code, and sweep all sixteen byte-enable patterns on the 32-bit bank. Reads and writes in different widths alternate, so the turnaround, the per-width latencies and the write-enable pulse width are each measured against counts the bench derives from the nanosecond figures.

// File: rtl/qlane_pkg.sv
package qlane_pkg;

  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    WD32 = 2'd0,
    WD16 = 2'd1,
    WD8  = 2'd2
  } width_t;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_TURN = 3'd1,
    PH_WSET = 3'd2,
    PH_WPUL = 3'd3,
    PH_WREC = 3'd4,
    PH_READ = 3'd5
  } phase_t;

  // Width code 2'b11 is folded onto the 32-bit arrangement.
  function automatic width_t mode_to_width(input logic [1:0] m);
    case (m)
      2'b01:   return WD16;
      2'b10:   return WD8;
      default: return WD32;
    endcase
  endfunction

  // Rounds a nanosecond minimum up to whole clocks, never below one.
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/qlane_lane_map.sv
module qlane_lane_map
  import qlane_pkg::*;
#(
  parameter int unsigned MEM_AW = 19,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned HAW   = MEM_AW + 2,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  width_t              wd_i,
  input  logic [HAW-1:0]      addr_i,
  input  logic [LANES-1:0]    be_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [MEM_AW-1:0]   maddr_o,
  output logic [LANES-1:0]    lane_o,
  output logic [LANES-1:0]    wmask_o,
  output logic [DW-1:0]       wdata_o,
  output logic [1:0]          bank_o
);

  assign bank_o = addr_i[HAW-1:HAW-2];

  always_comb begin
    case (wd_i)
      WD16:    maddr_o = addr_i[HAW-2:1];
      WD8:     maddr_o = addr_i[HAW-3:0];
      default: maddr_o = addr_i[HAW-1:2];
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [1:0] LID = 2'(l);
    logic              sel_l;
    logic              en_l;
    logic [LANE_W-1:0] byte_l;

    always_comb begin
      case (wd_i)
        WD16: begin
          sel_l  = (bank_o[1] == LID[1]);
          en_l   = be_i[l % 2];
          byte_l = wdata_i[(l % 2)*LANE_W +: LANE_W];
        end
        WD8: begin
          sel_l  = (bank_o == LID);
          en_l   = be_i[0];
          byte_l = wdata_i[LANE_W-1:0];
        end
        default: begin
          sel_l  = 1'b1;
          en_l   = be_i[l];
          byte_l = wdata_i[l*LANE_W +: LANE_W];
        end
      endcase
    end

    assign lane_o[l]                      = sel_l;
    assign wmask_o[l]                     = sel_l & en_l;
    assign wdata_o[l*LANE_W +: LANE_W]    = byte_l;
  end

endmodule

// File: rtl/qlane_rd_steer.sv
module qlane_rd_steer
  import qlane_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  width_t         wd_i,
  input  logic [1:0]     bank_i,
  input  logic [DW-1:0]  dq_i,
  output logic [DW-1:0]  rdata_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_out
    localparam logic [1:0] LID = 2'(l);
    logic [1:0]        src_l;
    logic [LANE_W-1:0] byte_l;

    always_comb begin
      src_l  = LID;
      byte_l = '0;
      case (wd_i)
        WD16: begin
          src_l = {bank_i[1], LID[0]};
          if (l < 2) byte_l = dq_i[src_l*LANE_W +: LANE_W];
        end
        WD8: begin
          src_l = bank_i;
          if (l == 0) byte_l = dq_i[src_l*LANE_W +: LANE_W];
        end
        default: byte_l = dq_i[l*LANE_W +: LANE_W];
      endcase
    end

    assign rdata_o[l*LANE_W +: LANE_W] = byte_l;
  end

endmodule

// File: rtl/qlane_seq.sv
module qlane_seq
  import qlane_pkg::*;
#(
  parameter int unsigned N_AS  = 1,
  parameter int unsigned N_WP  = 2,
  parameter int unsigned N_REC = 1,
  parameter int unsigned N_RD  = 2,
  parameter int unsigned N_TA  = 1,
  localparam int unsigned N_MAX = umax(umax(umax(N_AS, N_WP), umax(N_REC, N_RD)), N_TA),
  localparam int unsigned CW    = $clog2(N_MAX + 1)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_i,
  input  logic   wr_i,
  output logic   accept_o,
  output logic   cap_o,
  output logic   ready_o,
  output phase_t ph_q_o,
  output phase_t ph_d_o
);

  localparam logic [CW-1:0] C_AS  = CW'(N_AS - 1);
  localparam logic [CW-1:0] C_WP  = CW'(N_WP - 1);
  localparam logic [CW-1:0] C_REC = CW'(N_REC - 1);
  localparam logic [CW-1:0] C_RD  = CW'(N_RD - 1);
  localparam logic [CW-1:0] C_TA  = CW'(N_TA - 1);

  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;
  logic          lrd_q, lrd_d;
  logic          last;

  assign last = (cnt_q == '0);

  always_comb begin
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    rdy_d    = 1'b0;
    lrd_d    = lrd_q;
    accept_o = 1'b0;
    cap_o    = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (req_i && !rdy_q) begin
          accept_o = 1'b1;
          if (wr_i) begin
            lrd_d = 1'b0;
            if (lrd_q) begin
              ph_d  = PH_TURN;
              cnt_d = C_TA;
            end else begin
              ph_d  = PH_WSET;
              cnt_d = C_AS;
            end
          end else begin
            ph_d  = PH_READ;
            cnt_d = C_RD;
          end
        end
      end
      PH_TURN: begin
        if (last) begin ph_d = PH_WSET; cnt_d = C_AS; end
        else cnt_d = cnt_q - 1'b1;
      end
      PH_WSET: begin
        if (last) begin ph_d = PH_WPUL; cnt_d = C_WP; end
        else cnt_d = cnt_q - 1'b1;
      end
      PH_WPUL: begin
        if (last) begin ph_d = PH_WREC; cnt_d = C_REC; end
        else cnt_d = cnt_q - 1'b1;
      end
      PH_WREC: begin
        if (last) begin ph_d = PH_IDLE; rdy_d = 1'b1; end
        else cnt_d = cnt_q - 1'b1;
      end
      PH_READ: begin
        if (last) begin
          ph_d  = PH_IDLE;
          rdy_d = 1'b1;
          cap_o = 1'b1;
          lrd_d = 1'b1;
        end else cnt_d = cnt_q - 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      rdy_q <= 1'b0;
      lrd_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
      lrd_q <= lrd_d;
    end
  end

  assign ready_o = rdy_q;
  assign ph_q_o  = ph_q;
  assign ph_d_o  = ph_d;

  // R10: a transaction is only taken from idle when no ready pulse is pending
  assert_accept_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> (ph_q == PH_IDLE && !rdy_q));

endmodule

// File: rtl/qlane_sram_ctrl.sv
module qlane_sram_ctrl
  import qlane_pkg::*;
#(
  parameter int unsigned MEM_AW = 19,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned CLK_NS = 10,
  parameter int unsigned T_WC   = 18,
  parameter int unsigned T_AS   = 2,
  parameter int unsigned T_WP   = 12,
  parameter int unsigned T_DS   = 8,
  parameter int unsigned T_AA   = 18,
  parameter int unsigned T_HZ   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode_i,
  input  logic                     req_i,
  input  logic                     wr_i,
  input  logic [MEM_AW+1:0]        addr_i,
  input  logic [4*LANE_W-1:0]      wdata_i,
  input  logic [3:0]               be_i,
  output logic                     ready_o,
  output logic [4*LANE_W-1:0]      rdata_o,
  output logic [MEM_AW-1:0]        mem_addr_o,
  output logic [3:0]               mem_cs_n_o,
  output logic [3:0]               mem_we_n_o,
  output logic                     mem_oe_n_o,
  output logic [4*LANE_W-1:0]      mem_dq_o,
  output logic                     mem_dq_oe_o,
  input  logic [4*LANE_W-1:0]      mem_dq_i
);

  localparam int unsigned DW    = LANES * LANE_W;
  localparam int unsigned N_AS  = ns2cyc(T_AS, CLK_NS);
  localparam int unsigned N_WP  = umax(ns2cyc(T_WP, CLK_NS), ns2cyc(T_DS, CLK_NS));
  localparam int unsigned N_WC  = ns2cyc(T_WC, CLK_NS);
  localparam int unsigned N_REC = (N_WC > N_AS + N_WP) ? (N_WC - N_AS - N_WP) : 1;
  localparam int unsigned N_RD  = ns2cyc(T_AA, CLK_NS);
  localparam int unsigned N_TA  = ns2cyc(T_HZ, CLK_NS);

  width_t              wd_in, wd_q;
  logic [MEM_AW-1:0]   map_addr, maddr_q;
  logic [LANES-1:0]    map_lane, lane_q, m_lane;
  logic [LANES-1:0]    map_wmask, wmask_q, m_wmask;
  logic [DW-1:0]       map_wdata, wdat_q;
  logic [1:0]          map_bank, bank_q;
  logic                accept, cap;
  phase_t              ph_q, ph_d;
  logic [LANES-1:0]    cs_n_q, cs_n_d, we_n_q, we_n_d;
  logic                oe_n_q, oe_n_d, dqoe_q, dqoe_d;
  logic [DW-1:0]       rd_steered, rdata_q;

  assign wd_in = mode_to_width(mode_i);

  qlane_lane_map #(.MEM_AW(MEM_AW), .LANE_W(LANE_W)) u_map (
    .wd_i    (wd_in),
    .addr_i  (addr_i),
    .be_i    (be_i),
    .wdata_i (wdata_i),
    .maddr_o (map_addr),
    .lane_o  (map_lane),
    .wmask_o (map_wmask),
    .wdata_o (map_wdata),
    .bank_o  (map_bank)
  );

  qlane_seq #(.N_AS(N_AS), .N_WP(N_WP), .N_REC(N_REC), .N_RD(N_RD), .N_TA(N_TA)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .wr_i     (wr_i),
    .accept_o (accept),
    .cap_o    (cap),
    .ready_o  (ready_o),
    .ph_q_o   (ph_q),
    .ph_d_o   (ph_d)
  );

  qlane_rd_steer #(.LANE_W(LANE_W)) u_rd (
    .wd_i    (wd_q),
    .bank_i  (bank_q),
    .dq_i    (mem_dq_i),
    .rdata_o (rd_steered)
  );

  // Lane decode for the cycle being entered: fresh at acceptance, held after.
  assign m_lane  = accept ? map_lane  : lane_q;
  assign m_wmask = accept ? map_wmask : wmask_q;

  always_comb begin
    cs_n_d = '1;
    we_n_d = '1;
    oe_n_d = 1'b1;
    dqoe_d = 1'b0;
    case (ph_d)
      PH_WSET: cs_n_d = ~m_lane;
      PH_WPUL: begin
        cs_n_d = ~m_lane;
        we_n_d = ~m_wmask;
        dqoe_d = 1'b1;
      end
      PH_WREC: begin
        cs_n_d = ~m_lane;
        dqoe_d = (ph_q == PH_WPUL);
      end
      PH_READ: begin
        cs_n_d = ~m_lane;
        oe_n_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q    <= WD32;
      maddr_q <= '0;
      lane_q  <= '0;
      wmask_q <= '0;
      wdat_q  <= '0;
      bank_q  <= '0;
    end else if (accept) begin
      wd_q    <= wd_in;
      maddr_q <= map_addr;
      lane_q  <= map_lane;
      wmask_q <= map_wmask;
      wdat_q  <= map_wdata;
      bank_q  <= map_bank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= '1;
      we_n_q <= '1;
      oe_n_q <= 1'b1;
      dqoe_q <= 1'b0;
    end else begin
      cs_n_q <= cs_n_d;
      we_n_q <= we_n_d;
      oe_n_q <= oe_n_d;
      dqoe_q <= dqoe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata_q <= '0;
    else if (cap) rdata_q <= rd_steered;
  end

  assign mem_addr_o  = maddr_q;
  assign mem_dq_o    = wdat_q;
  assign mem_cs_n_o  = cs_n_q;
  assign mem_we_n_o  = we_n_q;
  assign mem_oe_n_o  = oe_n_q;
  assign mem_dq_oe_o = dqoe_q;
  assign rdata_o     = rdata_q;

  // Write-enable low-time monitor used by the pulse-width property.
  localparam int unsigned WLW = $clog2(N_WP + 2);
  logic [WLW-1:0] wl_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wl_cnt <= '0;
    else if (!(&mem_we_n_o))   wl_cnt <= wl_cnt + 1'b1;
    else                       wl_cnt <= '0;
  end

  assert_we_in_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mem_we_n_o) & mem_cs_n_o) == '0);

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(&mem_we_n_o) |-> $stable(mem_addr_o));

  assert_we_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((&mem_we_n_o) && wl_cnt != '0) |-> (wl_cnt == WLW'(N_WP)));

  assert_oe_excl_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n_o |-> (&mem_we_n_o));

  assert_drv_no_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe_o |-> mem_oe_n_o);

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (&mem_cs_n_o));

  assert_cs_group_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_q == WD32 && !(&mem_cs_n_o)) |-> (mem_cs_n_o == '0));

endmodule

// File: tb/qlane_sram_ctrl_tb.sv
module qlane_sram_ctrl_tb;

  localparam int MEM_AW = 3;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int CLK_NS = 10;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int E_AS  = cdiv(2);
  localparam int E_WP  = (cdiv(12) > cdiv(8)) ? cdiv(12) : cdiv(8);
  localparam int E_WC  = cdiv(18);
  localparam int E_REC = (E_WC > E_AS + E_WP) ? E_WC - E_AS - E_WP : 1;
  localparam int E_RD  = cdiv(18);
  localparam int E_TA  = cdiv(8);

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        mode;
  logic              req, wr;
  logic [MEM_AW+1:0] addr;
  logic [31:0]       wdata;
  logic [3:0]        be;
  logic              ready;
  logic [31:0]       rdata;
  logic [MEM_AW-1:0] mem_addr;
  logic [3:0]        mem_cs_n, mem_we_n;
  logic              mem_oe_n;
  logic [31:0]       mem_dq_o;
  logic              mem_dq_oe;
  logic [31:0]       mem_dq_i;

  int checks = 0;
  int fails  = 0;
  logic last_rd = 1'b0;
  int wl [4];

  logic [7:0] mem [4][DEPTH];
  logic [7:0] rf  [4][DEPTH];

  qlane_sram_ctrl #(
    .MEM_AW(MEM_AW), .LANE_W(8), .CLK_NS(CLK_NS),
    .T_WC(18), .T_AS(2), .T_WP(12), .T_DS(8), .T_AA(18), .T_HZ(8)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .req_i(req), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .be_i(be), .ready_o(ready), .rdata_o(rdata),
    .mem_addr_o(mem_addr), .mem_cs_n_o(mem_cs_n), .mem_we_n_o(mem_we_n),
    .mem_oe_n_o(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  always #5 clk = ~clk;

  // Behavioural lanes: a write lands when the lane strobe rises.
  logic [3:0] wstrb;
  assign wstrb = mem_we_n | mem_cs_n;
  for (genvar l = 0; l < 4; l++) begin : g_mem
    always @(posedge wstrb[l]) if (rst_n === 1'b1) mem[l][mem_addr] = mem_dq_o[l*8 +: 8];
    assign mem_dq_i[l*8 +: 8] = (!mem_cs_n[l] && !mem_oe_n && mem_we_n[l]) ? mem[l][mem_addr] : 8'hEE;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Pulse-width and driver-window monitor.
  always @(negedge clk) if (rst_n === 1'b1) begin
    for (int l = 0; l < 4; l++) begin
      if (!mem_we_n[l]) wl[l]++;
      else if (wl[l] != 0) begin
        chk(wl[l] == E_WP, "R5 we low cycles", wl[l], E_WP);
        chk(mem_dq_oe == 1'b1, "R8 driver after we rise", {31'b0, mem_dq_oe}, 1);
        wl[l] = 0;
      end
    end
    if (mem_dq_oe) chk(mem_oe_n == 1'b1, "R8 driver with oe", {31'b0, mem_oe_n}, 1);
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] m, input logic [MEM_AW+1:0] a);
    int b, ma;
    if (m == 2'b01) begin
      b = a[MEM_AW+1]; ma = a[MEM_AW:1];
      return {16'h0, rf[2*b+1][ma], rf[2*b][ma]};
    end else if (m == 2'b10) begin
      b = a[MEM_AW+1:MEM_AW]; ma = a[MEM_AW-1:0];
      return {24'h0, rf[b][ma]};
    end else begin
      ma = a[MEM_AW+1:2];
      return {rf[3][ma], rf[2][ma], rf[1][ma], rf[0][ma]};
    end
  endfunction

  task automatic ref_wr(input logic [1:0] m, input logic [MEM_AW+1:0] a, input logic [31:0] d, input logic [3:0] e);
    int b, ma;
    if (m == 2'b01) begin
      b = a[MEM_AW+1]; ma = a[MEM_AW:1];
      for (int k = 0; k < 2; k++) if (e[k]) rf[2*b+k][ma] = d[8*k +: 8];
    end else if (m == 2'b10) begin
      b = a[MEM_AW+1:MEM_AW]; ma = a[MEM_AW-1:0];
      if (e[0]) rf[b][ma] = d[7:0];
    end else begin
      ma = a[MEM_AW+1:2];
      for (int k = 0; k < 4; k++) if (e[k]) rf[k][ma] = d[8*k +: 8];
    end
  endtask

  task automatic txn(input logic w, input logic [MEM_AW+1:0] a, input logic [31:0] d,
                     input logic [3:0] e, input string tag);
    int lat, elat;
    logic [31:0] got;
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d; be = e;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!ready && lat < 100);
    got = rdata;
    chk(mem_cs_n == 4'hF, "R10 cs idle at ready", {28'h0, mem_cs_n}, 32'hF);
    req = 1'b0;
    if (w) begin
      elat = E_AS + E_WP + E_REC + 1 + (last_rd ? E_TA : 0);
      chk(lat == elat, last_rd ? "R9 write latency after read" : "R6 write latency", lat, elat);
      ref_wr(mode, a, d, e);
      last_rd = 1'b0;
    end else begin
      elat = E_RD + 1;
      chk(lat == elat, "R7 read latency", lat, elat);
      chk(got == exp_rd(mode, a), tag, got, exp_rd(mode, a));
      last_rd = 1'b1;
    end
    @(negedge clk);
    chk(ready == 1'b0, "R10 ready single cycle", {31'b0, ready}, 0);
  endtask

  initial begin
    for (int l = 0; l < 4; l++) begin
      wl[l] = 0;
      for (int i = 0; i < DEPTH; i++) begin mem[l][i] = 8'h00; rf[l][i] = 8'h00; end
    end
    rst_n = 1'b0; mode = 2'b00; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0; be = '0;
    repeat (3) @(negedge clk);
    chk(mem_cs_n == 4'hF && mem_we_n == 4'hF, "R11 strobes in reset", {24'h0, mem_cs_n, mem_we_n}, 32'hFF);
    chk(mem_oe_n == 1'b1 && mem_dq_oe == 1'b0 && ready == 1'b0, "R11 oe/drv/ready in reset",
        {29'h0, mem_oe_n, mem_dq_oe, ready}, 32'h4);
    rst_n = 1'b1;

    // R1: full words in the 32-bit bank
    mode = 2'b00;
    for (int a = 0; a < DEPTH; a++) txn(1'b1, 5'(a*4), 32'hA0B1C2D3 ^ (32'h01010101 * a), 4'hF, "R1 wr");
    for (int a = 0; a < DEPTH; a++) txn(1'b0, 5'(a*4), 0, 4'hF, "R1 word readback");
    // R1/R12: every byte-enable pattern
    for (int e = 0; e < 16; e++) txn(1'b1, 5'((e % DEPTH)*4), 32'h11223344 + 32'h10101010 * e, 4'(e), "R1 wr be");
    for (int a = 0; a < DEPTH; a++) txn(1'b0, 5'(a*4), 0, 4'hF, "R12 byte enable readback");

    // R2: two 16-bit banks
    mode = 2'b01;
    for (int h = 0; h < 2*DEPTH; h++) txn(1'b1, 5'(h*2), 32'hFFFF0000 | (16'h5A3C ^ (16'h0101 * h)), 4'h3, "R2 wr");
    for (int h = 0; h < 2*DEPTH; h++) txn(1'b0, 5'(h*2), 0, 4'h3, "R2 halfword readback");
    txn(1'b1, 5'd0,  32'h0000BEEF, 4'h1, "R2 wr lo");
    txn(1'b1, 5'd18, 32'h0000CAFE, 4'h2, "R2 wr hi");
    txn(1'b1, 5'd6,  32'h00001234, 4'h0, "R12 wr none");
    txn(1'b0, 5'd0,  0, 4'h3, "R2 low byte only");
    txn(1'b0, 5'd18, 0, 4'h3, "R2 high byte only");
    txn(1'b0, 5'd6,  0, 4'h3, "R12 halfword untouched");

    // R3: four 8-bit banks
    mode = 2'b10;
    for (int b = 0; b < 4*DEPTH; b++) txn(1'b1, 5'(b), 32'hFFFFFF00 | 32'(8'h3C + 8'(b*7)), 4'h1, "R3 wr");
    for (int b = 0; b < 4*DEPTH; b++) txn(1'b0, 5'(b), 0, 4'h1, "R3 byte readback");
    txn(1'b1, 5'd13, 32'h000000AA, 4'hE, "R12 wr be0 clear");
    txn(1'b0, 5'd13, 0, 4'h1, "R12 byte untouched");

    // R4: reserved code acts as the 32-bit bank
    mode = 2'b11;
    for (int a = 0; a < DEPTH; a++) txn(1'b0, 5'(a*4), 0, 4'hF, "R4 word readback");
    txn(1'b1, 5'd20, 32'h89ABCDEF, 4'hF, "R4 wr");
    txn(1'b0, 5'd20, 0, 4'hF, "R4 word after write");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule